// File: doc/BRIEF.md
# Background Debug Serial Port

This block is the target side of a synchronous, full-duplex debug serial link. An external debug host owns the serial clock. The port runs in the processor's system-clock domain and samples the host clock and host data through a synchronizer. It detects rising and falling host-clock edges by comparing synchronized samples, so the host clock may run at any rate from DC up to half the system clock.

Every word on the link is a 17-bit frame. A status/control flag sits in bit 16 and a 16-bit data field sits in bits 15..0, and bit 16 travels first. While the host shifts a frame in, the port shifts its own response frame out. The processor side loads that response into a holding register. If nothing was loaded, the port answers with a fixed not-ready frame. A completed incoming frame is presented in parallel with a one-cycle valid strobe.

The port is live only while the debug-mode enable is high. Dropping the enable aborts any partial frame and releases the output line.

Top module: `dbgser_port`

## Requirements
- R1: After the 17th host-clock rising edge of a frame, `rx_valid` is high for exactly one system cycle. `rx_sc` then holds the first bit received and `rx_data` holds the following 16 bits, first-received bit in `rx_data[15]`.
- R2: On `tx_dout` the port sends the loaded response with the flag first, then data bit 15 down to bit 0. Each bit is valid before the host-clock rising edge that samples it.
- R3: Within a frame, `tx_dout` changes only in response to a host-clock falling edge. It stays stable while the host clock is high.
- R4: If no response was loaded since the previous frame started, the port sends the not-ready frame: flag 1 and data 0x0000. Between frames `tx_dout` shows that frame's flag.
- R5: A loaded response is sent in exactly one frame. The frame after it is the not-ready frame unless a new response is loaded.
- R6: While `dbg_en` is low, `tx_oe` and `tx_dout` are 0, no `rx_valid` pulse occurs, and host-clock activity is ignored.
- R7: Lowering `dbg_en` mid-frame discards the partial frame. After `dbg_en` returns high, the next 17 host-clock periods form a complete new frame.
- R8: After reset, `rx_valid` is 0 and no response is held. With `dbg_en` high, `tx_oe` is 1 and `tx_dout` is 1.
- R9: Reception is correct for host-clock phases as short as one system cycle and as long as many tens of cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dbg_en | input | 1 | Debug-mode enable, system-clock domain |
| host_clk | input | 1 | Serial clock from debug host (asynchronous) |
| host_din | input | 1 | Serial data from host (asynchronous) |
| tx_dout | output | 1 | Serial data to host |
| tx_oe | output | 1 | High while the port owns the output line |
| rsp_load | input | 1 | One-cycle strobe that loads the response word |
| rsp_sc | input | 1 | Status/control flag of the response |
| rsp_data | input | 16 | Data field of the response |
| rx_valid | output | 1 | One-cycle strobe: received frame ready |
| rx_sc | output | 1 | Received status/control flag |
| rx_data | output | 16 | Received data field |

## Verification
Host frames sweep every single-one position across all 17 bits, plus all-zeros, all-ones, both alternating patterns and an arithmetic sequence. Together these separate a wrong bit order, a bit slip by one position and a stuck bit on both directions, because each frame carries a rotated response. Frames with no loaded response and back-to-back frames after one load tell correct consumption of the holding register apart from a response that sticks or is never sent. Very short and very long host-clock phases show that edge detection does not depend on rate. Host-clock activity while disabled, and a frame aborted part-way, show whether the counter is truly gated and cleared.

// File: rtl/dbgser_pkg.sv
package dbgser_pkg;

    localparam int DATA_W  = 16;
    localparam int FRAME_W = DATA_W + 1;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic              sc;
        logic [DATA_W-1:0] data;
    } frame_t;

    localparam frame_t NOT_READY = '{sc: 1'b1, data: '0};

    // Move the next bit into the flag position for transmission.
    function automatic frame_t shift_out(input frame_t f);
        logic [FRAME_W-1:0] v;
        v = f;
        return frame_t'({v[FRAME_W-2:0], 1'b0});
    endfunction

endpackage

// File: rtl/dbgser_sync.sv
module dbgser_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= d;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stage_q[i] <= '0;
                else     stage_q[i] <= stage_q[i-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dbgser_edge.sv
module dbgser_edge (
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level;
    end

    assign rise = level & ~prev_q;
    assign fall = ~level & prev_q;
endmodule

// File: rtl/dbgser_shifter.sv
module dbgser_shifter
    import dbgser_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             rise,
    input  logic             fall,
    input  logic             din,
    input  logic             rsp_load,
    input  frame_t           rsp_frame,
    output logic             tx_bit,
    output logic             rx_valid,
    output frame_t           rx_frame,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] DONE = CNT_W'(FRAME_W);

    frame_t             hold_q;
    logic               hold_full_q;
    frame_t             tx_q;
    logic [DATA_W-1:0]  rx_q;
    frame_t             rx_frame_q;
    logic               rx_valid_q;
    logic [CNT_W-1:0]   cnt_q;
    frame_t             pending;
    logic               frame_start;

    assign pending     = hold_full_q ? hold_q : NOT_READY;
    assign frame_start = en && rise && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q      <= '0;
            hold_full_q <= 1'b0;
            tx_q        <= '0;
            rx_q        <= '0;
            rx_frame_q  <= '0;
            rx_valid_q  <= 1'b0;
            cnt_q       <= '0;
        end else begin
            rx_valid_q <= 1'b0;

            if (rsp_load) begin
                hold_q      <= rsp_frame;
                hold_full_q <= 1'b1;
            end else if (frame_start) begin
                hold_full_q <= 1'b0;
            end

            if (!en) begin
                cnt_q <= '0;
                tx_q  <= '0;
                rx_q  <= '0;
            end else if (rise) begin
                rx_q <= {rx_q[DATA_W-2:0], din};
                if (cnt_q == '0) tx_q <= pending;
                if (cnt_q == LAST) begin
                    rx_frame_q <= frame_t'({rx_q, din});
                    rx_valid_q <= 1'b1;
                end
                if (cnt_q != DONE) cnt_q <= cnt_q + 1'b1;
            end else if (fall && cnt_q != '0) begin
                if (cnt_q == DONE) cnt_q <= '0;
                else               tx_q  <= shift_out(tx_q);
            end
        end
    end

    assign tx_bit   = (cnt_q == '0) ? pending.sc : tx_q.sc;
    assign rx_valid = rx_valid_q;
    assign rx_frame = rx_frame_q;
    assign cnt      = cnt_q;
endmodule

// File: rtl/dbgser_port.sv
module dbgser_port
    import dbgser_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dbg_en,
    input  logic              host_clk,
    input  logic              host_din,
    output logic              tx_dout,
    output logic              tx_oe,
    input  logic              rsp_load,
    input  logic              rsp_sc,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              rx_valid,
    output logic              rx_sc,
    output logic [DATA_W-1:0] rx_data
);
    logic [1:0]       pin_sync;
    logic             edge_rise;
    logic             edge_fall;
    logic             tx_bit;
    logic [CNT_W-1:0] bit_cnt;
    frame_t           rsp_frame;
    frame_t           rx_frame;

    // Clock and data share one synchronizer so their delays match.
    dbgser_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   ({host_clk, host_din}),
        .q   (pin_sync)
    );

    dbgser_edge edge_i (
        .clk   (clk),
        .rst   (rst),
        .level (pin_sync[1]),
        .rise  (edge_rise),
        .fall  (edge_fall)
    );

    assign rsp_frame = '{sc: rsp_sc, data: rsp_data};

    dbgser_shifter shift_i (
        .clk       (clk),
        .rst       (rst),
        .en        (dbg_en),
        .rise      (edge_rise),
        .fall      (edge_fall),
        .din       (pin_sync[0]),
        .rsp_load  (rsp_load),
        .rsp_frame (rsp_frame),
        .tx_bit    (tx_bit),
        .rx_valid  (rx_valid),
        .rx_frame  (rx_frame),
        .cnt       (bit_cnt)
    );

    assign tx_oe   = dbg_en;
    assign tx_dout = dbg_en & tx_bit;
    assign rx_sc   = rx_frame.sc;
    assign rx_data = rx_frame.data;
endmodule

// File: rtl/dbgser_port_chk.sv
module dbgser_port_chk
    import dbgser_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             dbg_en,
    input logic             rise,
    input logic             fall,
    input logic [CNT_W-1:0] cnt,
    input logic             tx_dout,
    input logic             rx_valid
);
    assert_valid_single_R1: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    assert_valid_after_last_R1: assert property (@(posedge clk) disable iff (rst)
        (dbg_en && rise && int'(cnt) == FRAME_W - 1) |=> rx_valid);

    assert_tx_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (dbg_en && cnt != '0 && !fall) ##1 dbg_en |-> $stable(tx_dout));

    assert_disable_clears_R6: assert property (@(posedge clk) disable iff (rst)
        !dbg_en |=> (cnt == '0 && !rx_valid));

    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) <= FRAME_W);
endmodule

bind dbgser_port dbgser_port_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .dbg_en   (dbg_en),
    .rise     (edge_rise),
    .fall     (edge_fall),
    .cnt      (bit_cnt),
    .tx_dout  (tx_dout),
    .rx_valid (rx_valid)
);

// File: tb/dbgser_port_tb.sv
`timescale 1ns/1ps
module dbgser_port_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        dbg_en = 1'b0;
    logic        host_clk = 1'b0;
    logic        host_din = 1'b0;
    logic        tx_dout;
    logic        tx_oe;
    logic        rsp_load = 1'b0;
    logic        rsp_sc = 1'b0;
    logic [15:0] rsp_data = '0;
    logic        rx_valid;
    logic        rx_sc;
    logic [15:0] rx_data;

    int n_cmp = 0;
    int n_bad = 0;
    int pulses = 0;
    logic [16:0] last_rx = '0;
    bit done = 0;

    localparam logic [16:0] NR = 17'h10000;

    always #2.5 clk = ~clk;

    dbgser_port dut_i (
        .clk(clk), .rst(rst), .dbg_en(dbg_en),
        .host_clk(host_clk), .host_din(host_din),
        .tx_dout(tx_dout), .tx_oe(tx_oe),
        .rsp_load(rsp_load), .rsp_sc(rsp_sc), .rsp_data(rsp_data),
        .rx_valid(rx_valid), .rx_sc(rx_sc), .rx_data(rx_data)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            pulses++;
            last_rx = {rx_sc, rx_data};
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_rsp(input logic [16:0] f);
        @(negedge clk);
        rsp_load = 1'b1;
        rsp_sc   = f[16];
        rsp_data = f[15:0];
        @(negedge clk);
        rsp_load = 1'b0;
    endtask

    // Host side: drive nbits bits MSB first, sample the port's bit before each rise.
    task automatic xfer(input logic [16:0] hv, input int ph, input int nbits,
                        output logic [16:0] got, output bit unstable);
        got = '0;
        unstable = 0;
        for (int i = 16; i > 16 - nbits; i--) begin
            host_din = hv[i];
            wait_cyc(ph);
            got[i] = tx_dout;
            host_clk = 1'b1;
            wait_cyc(ph);
            if (tx_dout !== got[i]) unstable = 1;
            host_clk = 1'b0;
        end
        wait_cyc(ph + 6);
    endtask

    task automatic frame_check(input logic [16:0] hv, input logic [16:0] exp_tx,
                               input int ph, input bit check_tx, input string tag);
        logic [16:0] got;
        bit unstable;
        pulses = 0;
        xfer(hv, ph, 17, got, unstable);
        chk(pulses == 1, {tag, " R1 pulse count"}, pulses, 1);
        chk(last_rx == hv, {tag, " R1 rx frame"}, {15'd0, last_rx}, {15'd0, hv});
        if (check_tx) begin
            chk(got == exp_tx, {tag, " R2 tx frame"}, {15'd0, got}, {15'd0, exp_tx});
            chk(!unstable, {tag, " R3 tx stable in high phase"}, {31'd0, unstable}, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [16:0] got;
        logic [16:0] pat;
        bit unstable;

        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(2);

        // R8 / R6: reset state, port disabled
        chk(rx_valid == 1'b0, "R8 rx_valid after reset", {31'd0, rx_valid}, 0);
        chk(tx_oe == 1'b0, "R6 tx_oe while disabled", {31'd0, tx_oe}, 0);
        chk(tx_dout == 1'b0, "R6 tx_dout while disabled", {31'd0, tx_dout}, 0);

        dbg_en = 1'b1;
        wait_cyc(2);
        chk(tx_oe == 1'b1, "R8 tx_oe enabled", {31'd0, tx_oe}, 1);
        chk(tx_dout == 1'b1, "R8 R4 idle flag bit", {31'd0, tx_dout}, 1);

        // R4: no response loaded
        frame_check(17'h0A5C3, NR, 5, 1, "R4 not-ready");

        // Sweep with rotated responses (R1, R2, R3)
        for (int k = 0; k < 30; k++) begin
            if (k < 17)       pat = 17'd1 << k;
            else if (k == 17) pat = 17'h00000;
            else if (k == 18) pat = 17'h1FFFF;
            else if (k == 19) pat = 17'h0AAAA;
            else if (k == 20) pat = 17'h15555;
            else              pat = 17'((k * 17'h2B3D + 17'h00F1) & 17'h1FFFF);
            load_rsp({pat[0], pat[16:1]} ^ 17'h0F0F0);
            frame_check(pat, {pat[0], pat[16:1]} ^ 17'h0F0F0, 5, 1, "sweep");
        end

        // R5: one load, two frames
        load_rsp(17'h0BEEF);
        frame_check(17'h13579, 17'h0BEEF, 5, 1, "R5 first");
        frame_check(17'h02468, NR, 5, 1, "R5 second not-ready");

        // R9: fastest host clock, rx only
        for (int k = 0; k < 6; k++) begin
            pat = 17'((k * 17'h1D2B + 17'h1357) & 17'h1FFFF);
            frame_check(pat, NR, 1, 0, "R9 fast");
        end
        // R9: very slow host clock
        load_rsp(17'h1C3A5);
        frame_check(17'h05A5A, 17'h1C3A5, 40, 1, "R9 slow");

        // R6: host activity while disabled
        dbg_en = 1'b0;
        wait_cyc(2);
        pulses = 0;
        xfer(17'h1FFFF, 3, 17, got, unstable);
        chk(pulses == 0, "R6 no pulse while disabled", pulses, 0);
        chk(got == 17'h0, "R6 tx_dout low while disabled", {15'd0, got}, 0);
        chk(tx_oe == 1'b0, "R6 tx_oe low while disabled", {31'd0, tx_oe}, 0);

        // R7: abort mid-frame, then a fresh full frame
        dbg_en = 1'b1;
        wait_cyc(2);
        pulses = 0;
        xfer(17'h1F000, 5, 5, got, unstable);
        dbg_en = 1'b0;
        wait_cyc(4);
        dbg_en = 1'b1;
        wait_cyc(4);
        chk(pulses == 0, "R7 no pulse for partial frame", pulses, 0);
        frame_check(17'h0C0DE, NR, 5, 1, "R7 fresh frame");
        frame_check(17'h1ABCD, NR, 5, 1, "R7 following frame");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule